// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog with a small memory-mapped register set. A clock-enable pulse from a slow, free-running source (`wdg_tick_i`) advances a programmable divider, and each divider output step decrements a 12-bit countdown. When the countdown runs out, the block issues a one-cycle reset request and then starts the next period on its own. Software keeps the system alive by writing a refresh code to the command register before each period ends.

Every control action goes through magic values written to the command register. One value starts the watchdog, and software cannot stop it afterwards. A second value refreshes the countdown. A third value opens the divider-select and period registers for writing. Any other command value closes them again. New divider and period values do not take effect at once. Each one passes through a short synchronisation delay, counted in slow ticks, and a status register shows which updates are still pending.

Top module: `key_watchdog`

## Requirements
- R1: After reset, reads return divider code 0 at offset 0x04, period 0xFFF at offset 0x08 and status 0 at offset 0x0C. `wdg_reset_req_o` stays low and no request appears while the watchdog has not been started.
- R2: Writing 0x5555 to the command register (offset 0x00; only bits [15:0] are compared) opens configuration writes. Offset 0x04 then takes bits [2:0] as the divider code, and offset 0x08 takes bits [11:0] as the period. Reads return the written value zero-extended.
- R3: Any command write other than 0x5555 closes configuration writes. Writes to 0x04 or 0x08 while closed change neither the read-back value nor the status.
- R4: Status bit 0 means a divider update is pending, and bit 1 means a period update is pending. A flag reads 1 from the cycle after an accepted write. It clears after `SYNC_TICKS` (default 5) cycles with `wdg_tick_i` high, when the new value takes effect. It holds while `wdg_tick_i` is low.
- R5: Writing 0xCCCC starts the watchdog from the applied period with a fresh divider phase. No later command write, including a repeated 0xCCCC, stops it or restarts its count.
- R6: A reset request is issued D×(P+1) ticks after a start or refresh. P is the applied period, and D is 4<<code for codes 0..6 and 256 for code 7.
- R7: Writing 0xAAAA reloads the countdown from the applied period and resets the divider phase.
- R8: `wdg_reset_req_o` is high for exactly one cycle. The countdown then reloads by itself, and the next request follows one full period later.
- R9: Reads of the command register, and of any offset beyond 0x0C, return 0.
- R10: The divider and countdown advance only in cycles where `wdg_tick_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wdg_tick_i | input | 1 | Slow-clock enable: one pulse per watchdog tick |
| bus_valid_i | input | 1 | Register access strobe |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W (4) | Byte address |
| bus_wdata_i | input | DATA_W (32) | Write data |
| bus_rdata_o | output | DATA_W (32) | Read data, same cycle, zero when no read |
| wdg_reset_req_o | output | 1 | One-cycle reset request on expiry |

## Verification
A write takes effect at the clock edge that accepts it. Read data is combinational, so a read placed half a cycle after a write already shows the new value and the pending flag. A pending flag drops exactly `SYNC_TICKS` ticked edges after its write, and the bench samples one edge either side of that point. The reset request rises D×(P+1) ticked edges after the start or refresh edge. The bench counts falling edges from the write edge to the first high sample, so an early, late or missing pulse shows up as a count mismatch. The same counting confirms the one-cycle width and the free-running repeat.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  localparam logic [15:0] CMD_REFRESH = 16'hAAAA;
  localparam logic [15:0] CMD_START   = 16'hCCCC;
  localparam logic [15:0] CMD_OPEN    = 16'h5555;

  // register slot selected by address bits [3:2]
  typedef enum logic [1:0] {
    SLOT_CMD  = 2'd0,
    SLOT_DIV  = 2'd1,
    SLOT_PER  = 2'd2,
    SLOT_STAT = 2'd3
  } reg_slot_e;

  typedef struct packed {
    logic start;
    logic refresh;
  } cmd_evt_t;

endpackage

// File: rtl/wdg_update_slot.sv
module wdg_update_slot #(
  parameter int             W          = 12,
  parameter logic [W-1:0]   RST_VAL    = '0,
  parameter int             SYNC_TICKS = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         wr_i,
  input  logic [W-1:0] wr_val_i,
  output logic [W-1:0] shadow_o,
  output logic [W-1:0] active_o,
  output logic         pending_o
);

  localparam int SC_W = $clog2(SYNC_TICKS + 1);

  logic [W-1:0]    shadow_q, shadow_d;
  logic [W-1:0]    active_q, active_d;
  logic [SC_W-1:0] scnt_q, scnt_d;
  logic            pend_q, pend_d;

  always_comb begin
    shadow_d = shadow_q;
    active_d = active_q;
    scnt_d   = scnt_q;
    pend_d   = pend_q;
    if (wr_i) begin
      shadow_d = wr_val_i;
      scnt_d   = SC_W'(SYNC_TICKS);
      pend_d   = 1'b1;
    end else if (pend_q && tick_i) begin
      if (scnt_q == SC_W'(1)) begin
        active_d = shadow_q;
        pend_d   = 1'b0;
        scnt_d   = '0;
      end else begin
        scnt_d = scnt_q - SC_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= RST_VAL;
      active_q <= RST_VAL;
      scnt_q   <= '0;
      pend_q   <= 1'b0;
    end else begin
      shadow_q <= shadow_d;
      active_q <= active_d;
      scnt_q   <= scnt_d;
      pend_q   <= pend_d;
    end
  end

  assign shadow_o  = shadow_q;
  assign active_o  = active_q;
  assign pending_o = pend_q;

  assert_pend_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !tick_i && !wr_i) |=> (pend_q && $stable(active_q)));

  assert_apply_on_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(active_q) |-> $fell(pend_q));

endmodule

// File: rtl/wdg_regfile.sv
module wdg_regfile
  import wdg_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 32,
  parameter int CNT_W      = 12,
  parameter int CODE_W     = 3,
  parameter int SYNC_TICKS = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              valid_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [CODE_W-1:0] div_code_o,
  output logic [CNT_W-1:0]  period_o,
  output cmd_evt_t          evt_o
);

  logic            in_range;
  reg_slot_e       slot;
  logic            wr_en, rd_en;
  logic            cmd_wr;
  logic [15:0]     cmd_val;
  logic            open_q, open_d;
  logic            div_wr, per_wr;
  logic            div_try, per_try;
  logic [CODE_W-1:0] div_shadow;
  logic [CNT_W-1:0]  per_shadow;
  logic            div_pend, per_pend;

  assign in_range = ((addr_i >> 4) == '0);
  assign slot     = reg_slot_e'(addr_i[3:2]);
  assign wr_en    = valid_i && write_i && in_range;
  assign rd_en    = valid_i && !write_i && in_range;
  assign cmd_wr   = wr_en && (slot == SLOT_CMD);
  assign cmd_val  = wdata_i[15:0];

  assign div_try  = wr_en && (slot == SLOT_DIV);
  assign per_try  = wr_en && (slot == SLOT_PER);
  assign div_wr   = div_try && open_q;
  assign per_wr   = per_try && open_q;

  always_comb begin
    open_d = open_q;
    if (cmd_wr) open_d = (cmd_val == CMD_OPEN);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) open_q <= 1'b0;
    else         open_q <= open_d;
  end

  assign evt_o.start   = cmd_wr && (cmd_val == CMD_START);
  assign evt_o.refresh = cmd_wr && (cmd_val == CMD_REFRESH);

  wdg_update_slot #(
    .W(CODE_W), .RST_VAL({CODE_W{1'b0}}), .SYNC_TICKS(SYNC_TICKS)
  ) u_div_slot (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
    .wr_i(div_wr), .wr_val_i(wdata_i[CODE_W-1:0]),
    .shadow_o(div_shadow), .active_o(div_code_o), .pending_o(div_pend)
  );

  wdg_update_slot #(
    .W(CNT_W), .RST_VAL({CNT_W{1'b1}}), .SYNC_TICKS(SYNC_TICKS)
  ) u_per_slot (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
    .wr_i(per_wr), .wr_val_i(wdata_i[CNT_W-1:0]),
    .shadow_o(per_shadow), .active_o(period_o), .pending_o(per_pend)
  );

  always_comb begin
    rdata_o = '0;
    if (rd_en) begin
      case (slot)
        SLOT_DIV:  rdata_o = DATA_W'(div_shadow);
        SLOT_PER:  rdata_o = DATA_W'(per_shadow);
        SLOT_STAT: rdata_o = DATA_W'({per_pend, div_pend});
        default:   rdata_o = '0;
      endcase
    end
  end

  assert_locked_div_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_try && !open_q) |=> $stable(div_shadow));

  assert_locked_per_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (per_try && !open_q) |=> $stable(per_shadow));

  assert_open_by_key_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(open_q) |-> $past(cmd_wr && (cmd_val == CMD_OPEN)));

endmodule

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
  parameter int CODE_W    = 3,
  parameter int BASE_LOG2 = 2,
  parameter int MAX_SHIFT = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              restart_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              step_o
);

  localparam int DIV_W = BASE_LOG2 + MAX_SHIFT;

  logic [DIV_W-1:0] pcnt_q, pcnt_d;
  logic [CODE_W-1:0] shift_c;
  logic [DIV_W:0]   one_hot;
  logic [DIV_W:0]   lim_full;
  logic [DIV_W-1:0] lim;
  logic             step;

  always_comb begin
    shift_c  = (int'(code_i) > MAX_SHIFT) ? CODE_W'(MAX_SHIFT) : code_i;
    one_hot  = (DIV_W+1)'(1) << (int'(shift_c) + BASE_LOG2);
    lim_full = one_hot - (DIV_W+1)'(1);
    lim      = lim_full[DIV_W-1:0];
  end

  assign step = tick_i && (pcnt_q >= lim);

  always_comb begin
    pcnt_d = pcnt_q;
    if (restart_i)   pcnt_d = '0;
    else if (step)   pcnt_d = '0;
    else if (tick_i) pcnt_d = pcnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pcnt_q <= '0;
    else         pcnt_q <= pcnt_d;
  end

  assign step_o = step;

  assert_step_spacing_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |=> !step_o);

  assert_step_needs_tick_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(pcnt_q) || $past(restart_i));

endmodule

// File: rtl/wdg_countdown.sv
module wdg_countdown
  import wdg_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cmd_evt_t         evt_i,
  input  logic             step_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             restart_o,
  output logic             req_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;
  logic             req_q, req_d;
  logic             load;

  assign load      = evt_i.refresh || (evt_i.start && !run_q);
  assign restart_o = load;

  always_comb begin
    run_d = run_q || evt_i.start;
    cnt_d = cnt_q;
    req_d = 1'b0;
    if (load) begin
      cnt_d = period_i;
    end else if (run_q && step_i) begin
      if (cnt_q == '0) begin
        cnt_d = period_i;
        req_d = 1'b1;
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '1;
      run_q <= 1'b0;
      req_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
      req_q <= req_d;
    end
  end

  assign req_o = req_q;

  assert_no_stop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |=> run_q);

  assert_pulse_width_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |=> !req_q);

  assert_req_needs_run_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |-> run_q);

endmodule

// File: rtl/key_watchdog.sv
module key_watchdog
  import wdg_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 32,
  parameter int CNT_W      = 12,
  parameter int CODE_W     = 3,
  parameter int BASE_LOG2  = 2,
  parameter int MAX_SHIFT  = 6,
  parameter int SYNC_TICKS = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wdg_tick_i,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              wdg_reset_req_o
);

  logic [1:0]        rst_sync_q;
  logic              rst_n;
  logic [CODE_W-1:0] div_code;
  logic [CNT_W-1:0]  period;
  cmd_evt_t          evt;
  logic              step;
  logic              restart;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  wdg_regfile #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
    .CODE_W(CODE_W), .SYNC_TICKS(SYNC_TICKS)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_n), .tick_i(wdg_tick_i),
    .valid_i(bus_valid_i), .write_i(bus_write_i),
    .addr_i(bus_addr_i), .wdata_i(bus_wdata_i), .rdata_o(bus_rdata_o),
    .div_code_o(div_code), .period_o(period), .evt_o(evt)
  );

  wdg_prescaler #(
    .CODE_W(CODE_W), .BASE_LOG2(BASE_LOG2), .MAX_SHIFT(MAX_SHIFT)
  ) u_div (
    .clk_i(clk_i), .rst_ni(rst_n), .tick_i(wdg_tick_i),
    .restart_i(restart), .code_i(div_code), .step_o(step)
  );

  wdg_countdown #(
    .CNT_W(CNT_W)
  ) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_n), .evt_i(evt), .step_i(step),
    .period_i(period), .restart_o(restart), .req_o(wdg_reset_req_o)
  );

endmodule

// File: tb/key_watchdog_tb.sv
module key_watchdog_tb_top;

  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;
  localparam int NV     = 27;
  localparam int LIMIT  = 20000;

  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_WT = 2'd2;

  // {op, addr, data}; for reads data is the expected value
  localparam logic [37:0] VEC [NV] = '{
    {OP_RD, 4'h4, 32'h0000_0000},   // R1
    {OP_RD, 4'h8, 32'h0000_0FFF},   // R1
    {OP_RD, 4'hC, 32'h0000_0000},   // R1
    {OP_RD, 4'h0, 32'h0000_0000},   // R9
    {OP_WR, 4'h4, 32'h0000_0003},   // R3 closed
    {OP_RD, 4'h4, 32'h0000_0000},   // R3
    {OP_RD, 4'hC, 32'h0000_0000},   // R3
    {OP_WR, 4'h0, 32'h0000_5555},   // R2 open
    {OP_WR, 4'h4, 32'hFFFF_FFF5},   // R2
    {OP_RD, 4'h4, 32'h0000_0005},   // R2
    {OP_RD, 4'hC, 32'h0000_0001},   // R4
    {OP_WR, 4'h8, 32'hABCD_E123},   // R2
    {OP_RD, 4'h8, 32'h0000_0123},   // R2
    {OP_RD, 4'hC, 32'h0000_0003},   // R4
    {OP_WT, 4'h0, 32'h0000_0008},
    {OP_RD, 4'hC, 32'h0000_0000},   // R4
    {OP_WR, 4'h0, 32'h0000_AAAA},   // R3 closes
    {OP_WR, 4'h8, 32'h0000_0007},
    {OP_RD, 4'h8, 32'h0000_0123},   // R3
    {OP_RD, 4'hC, 32'h0000_0000},   // R3
    {OP_WR, 4'h0, 32'h0001_5555},   // R2 low 16 bits
    {OP_WR, 4'h8, 32'h0000_0003},
    {OP_RD, 4'h8, 32'h0000_0003},   // R2
    {OP_WR, 4'h4, 32'h0000_0000},
    {OP_WT, 4'h0, 32'h0000_0008},
    {OP_RD, 4'hC, 32'h0000_0000},   // R4
    {OP_RD, 4'h0, 32'h0000_0000}    // R9
  };

  logic              clk = 1'b0;
  logic              rst_ni;
  logic              wdg_tick;
  logic              bus_valid, bus_write;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_wdata;
  logic [DATA_W-1:0] bus_rdata;
  logic              reset_req;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  key_watchdog dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .wdg_tick_i(wdg_tick),
    .bus_valid_i(bus_valid), .bus_write_i(bus_write),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
    .bus_rdata_o(bus_rdata), .wdg_reset_req_o(reset_req)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] exp, input string req);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1;
    check(bus_rdata == exp, req, bus_rdata, exp);
    bus_valid = 1'b0;
  endtask

  // counts falling edges from the current one until the request is seen
  task automatic measure(input int exp, input string req);
    int n = 0;
    while (!reset_req && n < LIMIT) begin
      @(negedge clk);
      n++;
    end
    check(n == exp, req, n, exp);
  endtask

  task automatic configure(input logic [2:0] code, input logic [11:0] per);
    bus_wr(4'h0, 32'h5555);
    bus_wr(4'h4, {29'd0, code});
    bus_wr(4'h8, {20'd0, per});
    repeat (8) @(negedge clk);
    bus_wr(4'h0, 32'hAAAA);
  endtask

  initial begin
    rst_ni = 1'b0; wdg_tick = 1'b1;
    bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (5) @(negedge clk);
    check(reset_req == 1'b0, "R1", reset_req, 0);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][37:36])
        OP_WR: bus_wr(VEC[i][35:32], VEC[i][31:0]);
        OP_RD: bus_rd(VEC[i][35:32], VEC[i][31:0], $sformatf("R1-table row %0d", i));
        default: repeat (int'(VEC[i][31:0])) @(negedge clk);
      endcase
    end

    // R1: not started, no request
    begin
      int highs = 0;
      for (int k = 0; k < 100; k++) begin
        @(negedge clk);
        if (reset_req) highs++;
      end
      check(highs == 0, "R1 idle", highs, 0);
    end

    // R5/R6: start, divider 4, period 3 -> 16
    bus_wr(4'h0, 32'hCCCC);
    measure(16, "R6 start timeout");
    @(negedge clk);
    check(reset_req == 1'b0, "R8 one-cycle pulse", reset_req, 0);
    measure(15, "R8 free-running repeat");

    // R7: refresh restarts the countdown
    repeat (5) @(negedge clk);
    bus_wr(4'h0, 32'hAAAA);
    measure(16, "R7 refresh");

    // R5: other values and a second start do not stop or restart
    bus_wr(4'h0, 32'hAAAA);
    bus_wr(4'h0, 32'h0000);
    measure(15, "R5 not stopped by other key");
    bus_wr(4'h0, 32'hAAAA);
    bus_wr(4'h0, 32'hCCCC);
    measure(15, "R5 second start ignored");

    // R6: other divider codes
    configure(3'd2, 12'd1);
    measure(32, "R6 code 2");
    configure(3'd7, 12'd1);
    measure(512, "R6 code 7");
    configure(3'd6, 12'd0);
    measure(256, "R6 code 6");

    // R10: no progress without ticks
    configure(3'd0, 12'd3);
    wdg_tick = 1'b0;
    begin
      int highs = 0;
      for (int k = 0; k < 100; k++) begin
        @(negedge clk);
        if (reset_req) highs++;
      end
      check(highs == 0, "R10 stalled", highs, 0);
    end
    wdg_tick = 1'b1;
    measure(16, "R10 resumes full period");

    // R4: pending flag holds without ticks, clears after SYNC_TICKS ticks
    wdg_tick = 1'b0;
    bus_wr(4'h0, 32'h5555);
    bus_wr(4'h8, 32'h3);
    repeat (20) @(negedge clk);
    bus_rd(4'hC, 32'h2, "R4 held while stalled");
    wdg_tick = 1'b1;
    repeat (4) @(negedge clk);
    bus_rd(4'hC, 32'h2, "R4 still pending at 4 ticks");
    @(negedge clk);
    bus_rd(4'hC, 32'h0, "R4 cleared at 5 ticks");
    bus_rd(4'h0 + 4'hC, 32'h0, "R4 status");
    bus_wr(4'h0, 32'h0);

    // R1: reset in the middle of a run
    rst_ni = 1'b0;
    #1;
    check(reset_req == 1'b0, "R1 async reset", reset_req, 0);
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk);
    bus_rd(4'h4, 32'h0,   "R1 divider after reset");
    bus_rd(4'h8, 32'hFFF, "R1 period after reset");
    bus_rd(4'hC, 32'h0,   "R1 status after reset");
    begin
      int highs = 0;
      for (int k = 0; k < 100; k++) begin
        @(negedge clk);
        if (reset_req) highs++;
      end
      check(highs == 0, "R1 stopped after reset", highs, 0);
    end
    bus_wr(4'h0, 32'hCCCC);
    measure(16384, "R6 default period");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule